// File: doc/BRIEF.md
# Eight-Bit Harvard Processor Core

This block is a small single-issue processor that completes one instruction every clock cycle. Every datum, instruction word and address is eight bits wide. Instructions come from a read-only program port, and data moves over a separate read/write port that also reaches memory-mapped peripherals. The core keeps four general registers and one equality flag. The last register also serves as the immediate register, which is filled four bits at a time. Control flow goes only through register-held targets. Conditional jumps test the equality flag.

Both memory read ports are combinational. The word at `imem_addr` and the byte at `dmem_addr` must be valid in the same cycle that the address is driven. A store is committed at the next rising clock edge while `dmem_we` is high. A single level-sensitive interrupt request is accepted between instructions. Accepting it saves the program counter, jumps to a fixed vector and blocks further requests until the return instruction runs.

Top module: `mini8_core`

## Requirements
- R1: A synchronous active-low reset sets the program counter, the flag, the saved return address and all four registers to zero and leaves interrupts unmasked. After release the first fetch is from address 0x00 and `dmem_we` is low.
- R2: Instruction bits [7:4] are the opcode, bits [3:2] select rd and bits [1:0] select rs. Opcode 0 copies rs into rd. Opcode 5 writes the bitwise inverse of rs into rd.
- R3: Opcodes 1, 2, 3 and 4 write rd+rs, rd-rs, rd AND rs and rd OR rs into rd, with sums and differences wrapping modulo 256.
- R4: Opcodes 6, 7 and 8 shift rd left logically, right logically and right arithmetically by the full 8-bit value of rs. An amount of 8 or more gives 0x00 for the logical shifts and eight copies of rd[7] for the arithmetic shift.
- R5: Opcode 9 sets the flag when rd equals rs and clears it otherwise. It changes no register.
- R6: Opcode 10 with bits [3:2]=00 loads the program counter from rs when the flag is 1. Otherwise it advances the counter by 1. Opcode 11 with bits [3:2]=00 always loads the counter from rs. All other opcode 10 and 11 words, except 0xB4, only advance the counter.
- R7: Opcode 12 places bits [3:0] into r3[7:4], and opcode 13 places bits [3:0] into r3[3:0]. The other nibble of r3 keeps its value in both cases.
- R8: Opcode 14 drives `dmem_addr` with rs and loads rd with `dmem_rdata`.
- R9: Opcode 15 drives `dmem_addr` with rs and `dmem_wdata` with rd, and raises `dmem_we`. `dmem_we` is high in no other case.
- R10: When `irq` is high and interrupts are unmasked, the instruction at the current address is not executed and nothing is stored. The current address is saved as the return address, the next fetch is from the vector address (0x01 by default), and interrupts become masked.
- R11: While masked, `irq` has no effect. The word 0xB4 loads the program counter from the saved return address and unmasks interrupts.
- R12: Every other instruction advances the program counter by 1, wrapping from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 8 | Program counter, the address of the instruction being fetched |
| imem_data | input | 8 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 8 | Data address, taken from the rs register |
| dmem_wdata | output | 8 | Store data, taken from the rd register |
| dmem_we | output | 1 | Store strobe, committed at the next rising edge |
| dmem_rdata | input | 8 | Data at `dmem_addr`, valid in the same cycle |
| irq | input | 1 | Interrupt request, level sensitive |

## Verification
Assertions check several things on every cycle:
- program-counter sequencing after ordinary instructions;
- unconditional jumps landing on the rs value;
- vectoring, return-address capture and masking on interrupt entry;
- the return instruction restoring the saved address;
- the store strobe only ever accompanying a store opcode;
- the immediate nibble writes preserving the other half of r3.

Only the bench's scenarios can show that register contents are correct over many instructions. It does this by comparing every fetch address and store against an instruction-level reference model, over directed shift and immediate sequences and random programs with varying interrupt rates. The same scenarios are the only evidence for the flag-dependent branch outcomes and for load data reaching later stores.

// File: rtl/mini8_pkg.sv
// Package: shared constants, opcode encoding and control bundle of the core.
// Assumes an 8-bit instruction word with the opcode in its top nibble.
package mini8_pkg;

    localparam int XLEN   = 8;
    localparam int NREG   = 4;
    localparam int RIDX_W = $clog2(NREG);
    localparam int NIB    = XLEN / 2;

    typedef enum logic [3:0] {
        OP_MOV  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_NOT  = 4'd5,
        OP_SLL  = 4'd6,
        OP_SRL  = 4'd7,
        OP_SRA  = 4'd8,
        OP_CMP  = 4'd9,
        OP_JE   = 4'd10,
        OP_JMP  = 4'd11,
        OP_LDIH = 4'd12,
        OP_LDIL = 4'd13,
        OP_LD   = 4'd14,
        OP_ST   = 4'd15
    } opcode_e;

    localparam logic [XLEN-1:0] IRET_WORD = 8'hB4;

    typedef enum logic [1:0] {
        PC_SEQ    = 2'd0,
        PC_COND   = 2'd1,
        PC_ALWAYS = 2'd2,
        PC_RET    = 2'd3
    } pc_sel_e;

    typedef struct packed {
        logic    rf_we;
        logic    from_mem;
        logic    flag_we;
        logic    imm_hi_we;
        logic    imm_lo_we;
        logic    mem_we;
        logic    is_iret;
        pc_sel_e pc_sel;
    } ctrl_t;

endpackage

// File: rtl/mini8_decode.sv
// Module: instruction decoder. Splits the word into fields and produces the
// control bundle. Purely combinational; assumes the word is stable for the cycle.
module mini8_decode
    import mini8_pkg::*;
(
    input  logic [XLEN-1:0]   instr,
    output opcode_e           op,
    output logic [RIDX_W-1:0] rd_idx,
    output logic [RIDX_W-1:0] rs_idx,
    output logic [NIB-1:0]    imm,
    output ctrl_t             ctrl
);

    assign op     = opcode_e'(instr[XLEN-1 -: 4]);
    assign rd_idx = instr[2*RIDX_W-1:RIDX_W];
    assign rs_idx = instr[RIDX_W-1:0];
    assign imm    = instr[NIB-1:0];

    // Map opcode and mode bits to the control bundle (R2-R9, R11).
    always_comb begin
        ctrl = '0;
        case (op)
            OP_MOV, OP_ADD, OP_SUB, OP_AND, OP_OR,
            OP_NOT, OP_SLL, OP_SRL, OP_SRA: ctrl.rf_we = 1'b1;
            OP_CMP:  ctrl.flag_we = 1'b1;
            OP_JE: begin
                if (rd_idx == '0) ctrl.pc_sel = PC_COND;
            end
            OP_JMP: begin
                if (instr == IRET_WORD) begin
                    ctrl.is_iret = 1'b1;
                    ctrl.pc_sel  = PC_RET;
                end else if (rd_idx == '0) begin
                    ctrl.pc_sel = PC_ALWAYS;
                end
            end
            OP_LDIH: ctrl.imm_hi_we = 1'b1;
            OP_LDIL: ctrl.imm_lo_we = 1'b1;
            OP_LD: begin
                ctrl.rf_we    = 1'b1;
                ctrl.from_mem = 1'b1;
            end
            OP_ST:   ctrl.mem_we = 1'b1;
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/mini8_alu.sv
// Module: arithmetic/logic unit. Computes rd-op-rs results and the equality
// indication. Combinational; assumes the shift amount is the whole rs value.
module mini8_alu
    import mini8_pkg::*;
(
    input  opcode_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] result,
    output logic            equal
);

    localparam int SH_W = $clog2(XLEN);

    logic                   sh_big;
    logic [SH_W-1:0]        sh_amt;
    logic signed [XLEN-1:0] a_s;

    assign sh_big = |b[XLEN-1:SH_W];
    assign sh_amt = b[SH_W-1:0];
    assign a_s    = a;
    assign equal  = (a == b);

    // Select the result for the current opcode (R2, R3, R4).
    always_comb begin
        case (op)
            OP_MOV:  result = b;
            OP_ADD:  result = a + b;
            OP_SUB:  result = a - b;
            OP_AND:  result = a & b;
            OP_OR:   result = a | b;
            OP_NOT:  result = ~b;
            OP_SLL:  result = sh_big ? '0 : (a << sh_amt);
            OP_SRL:  result = sh_big ? '0 : (a >> sh_amt);
            OP_SRA:  result = sh_big ? {XLEN{a[XLEN-1]}} : XLEN'(a_s >>> sh_amt);
            default: result = b;
        endcase
    end

endmodule

// File: rtl/mini8_regfile.sv
// Module: general register file with two read ports, one full-width write port
// and nibble write ports into the top register, which doubles as the immediate
// register. Assumes a full write and a nibble write never coincide.
module mini8_regfile #(
    parameter int WIDTH = 8,
    parameter int NUM   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NUM)-1:0]  ra_idx,
    input  logic [$clog2(NUM)-1:0]  rb_idx,
    output logic [WIDTH-1:0]        ra_data,
    output logic [WIDTH-1:0]        rb_data,
    input  logic                    we,
    input  logic [$clog2(NUM)-1:0]  w_idx,
    input  logic [WIDTH-1:0]        w_data,
    input  logic                    imm_hi_we,
    input  logic                    imm_lo_we,
    input  logic [WIDTH/2-1:0]      imm
);

    localparam int IDX_W   = $clog2(NUM);
    localparam int HALF    = WIDTH / 2;
    localparam int IMM_IDX = NUM - 1;

    logic [WIDTH-1:0] regs [NUM];

    for (genvar g = 0; g < NUM; g++) begin : g_reg
        logic [WIDTH-1:0] q;
        if (g == IMM_IDX) begin : g_imm
            // Top register: full writes plus nibble-wise immediate writes (R7).
            always_ff @(posedge clk) begin
                if (!rst_n)                           q <= '0;
                else if (we && w_idx == IDX_W'(g))    q <= w_data;
                else if (imm_hi_we)                   q[WIDTH-1:HALF] <= imm;
                else if (imm_lo_we)                   q[HALF-1:0] <= imm;
            end

            AST_IMM_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
                (imm_hi_we && !we) |=> (q[HALF-1:0] == $past(q[HALF-1:0]) && q[WIDTH-1:HALF] == $past(imm))); // R7
            AST_IMM_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
                (imm_lo_we && !imm_hi_we && !we) |=> (q[WIDTH-1:HALF] == $past(q[WIDTH-1:HALF]) && q[HALF-1:0] == $past(imm))); // R7
        end else begin : g_plain
            // Ordinary register: full-width writes only (R2, R3, R4, R8).
            always_ff @(posedge clk) begin
                if (!rst_n)                           q <= '0;
                else if (we && w_idx == IDX_W'(g))    q <= w_data;
            end
        end
        assign regs[g] = q;
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];

endmodule

// File: rtl/mini8_core.sv
// Module: top of the eight-bit Harvard core. Executes one instruction per
// cycle from a combinational program port, with a combinational data read port,
// a synchronous data write strobe and one maskable interrupt.
// Assumes both memories answer within the same cycle as the address.
module mini8_core
    import mini8_pkg::*;
#(
    parameter logic [7:0] IRQ_VECTOR = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [7:0] imem_addr,
    input  logic [7:0] imem_data,
    output logic [7:0] dmem_addr,
    output logic [7:0] dmem_wdata,
    output logic       dmem_we,
    input  logic [7:0] dmem_rdata,
    input  logic       irq
);

    logic [XLEN-1:0]   pc_q, pc_next, ret_q;
    logic              flag_q, masked_q, take_irq;
    opcode_e           op;
    logic [RIDX_W-1:0] rd_idx, rs_idx;
    logic [NIB-1:0]    imm;
    ctrl_t             ctrl;
    logic [XLEN-1:0]   rd_val, rs_val, alu_res, wb_data;
    logic              alu_eq;

    mini8_decode u_dec (
        .instr  (imem_data),
        .op     (op),
        .rd_idx (rd_idx),
        .rs_idx (rs_idx),
        .imm    (imm),
        .ctrl   (ctrl)
    );

    mini8_regfile #(.WIDTH(XLEN), .NUM(NREG)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ra_idx    (rd_idx),
        .rb_idx    (rs_idx),
        .ra_data   (rd_val),
        .rb_data   (rs_val),
        .we        (ctrl.rf_we && !take_irq),
        .w_idx     (rd_idx),
        .w_data    (wb_data),
        .imm_hi_we (ctrl.imm_hi_we && !take_irq),
        .imm_lo_we (ctrl.imm_lo_we && !take_irq),
        .imm       (imm)
    );

    mini8_alu u_alu (
        .op     (op),
        .a      (rd_val),
        .b      (rs_val),
        .result (alu_res),
        .equal  (alu_eq)
    );

    assign take_irq   = irq && !masked_q;
    assign wb_data    = ctrl.from_mem ? dmem_rdata : alu_res;
    assign imem_addr  = pc_q;
    assign dmem_addr  = rs_val;
    assign dmem_wdata = rd_val;
    assign dmem_we    = ctrl.mem_we && !take_irq;

    // Choose the next fetch address: vector, jump target, return or sequential.
    always_comb begin
        if (take_irq) begin
            pc_next = IRQ_VECTOR;
        end else begin
            case (ctrl.pc_sel)
                PC_COND:   pc_next = flag_q ? rs_val : pc_q + XLEN'(1);
                PC_ALWAYS: pc_next = rs_val;
                PC_RET:    pc_next = ret_q;
                default:   pc_next = pc_q + XLEN'(1);
            endcase
        end
    end

    // Program counter register (R1, R6, R10, R11, R12).
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    // Equality flag, written only by compare (R5).
    always_ff @(posedge clk) begin
        if (!rst_n)                          flag_q <= 1'b0;
        else if (ctrl.flag_we && !take_irq)  flag_q <= alu_eq;
    end

    // Return address capture and interrupt mask (R10, R11).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q    <= '0;
            masked_q <= 1'b0;
        end else if (take_irq) begin
            ret_q    <= pc_q;
            masked_q <= 1'b1;
        end else if (ctrl.is_iret) begin
            masked_q <= 1'b0;
        end
    end

    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !masked_q) |=> (imem_addr == IRQ_VECTOR)); // R10
    AST_IRQ_SAVES_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !masked_q) |=> (ret_q == $past(imem_addr) && masked_q)); // R10
    AST_IRET_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_irq && imem_data == IRET_WORD) |=> (imem_addr == $past(ret_q) && !masked_q)); // R11
    AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_irq && (imem_data[7:4] <= 4'd9 || imem_data[7:4] >= 4'd12))
            |=> (imem_addr == 8'($past(imem_addr) + 8'd1))); // R12
    AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_irq && imem_data[7:2] == 6'b101100) |=> (imem_addr == $past(dmem_addr))); // R6
    AST_WE_ONLY_ST: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (imem_data[7:4] == 4'hF && !irq | masked_q)); // R9

endmodule

// File: tb/tb_mini8_core.sv
// Bench: an instruction-level reference model drives expectations. Directed
// programs and seeded random programs with random interrupts are compared
// cycle by cycle at the fetch and store ports.
module tb_mini8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] imem_addr, dmem_addr, dmem_wdata, dmem_rdata, imem_data;
    logic       dmem_we;
    logic       irq = 1'b0;

    logic [7:0] imem  [256];
    logic [7:0] dmem  [256];
    logic [7:0] mdmem [256];

    logic [7:0] m_pc, m_ret;
    logic [7:0] m_r [4];
    logic       m_flag, m_mask;
    string      last_tag;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    mini8_core dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata),
        .irq        (irq)
    );

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h (pc=%h)", tag, act, exp, m_pc);
        end
    endtask

    // Bit-serial shifts, independent of any wide shifter.
    function automatic logic [7:0] f_sll(input logic [7:0] v, input logic [7:0] n);
        for (int i = 0; i < 8; i++) if (i < n) v = {v[6:0], 1'b0};
        return v;
    endfunction
    function automatic logic [7:0] f_srl(input logic [7:0] v, input logic [7:0] n);
        for (int i = 0; i < 8; i++) if (i < n) v = {1'b0, v[7:1]};
        return v;
    endfunction
    function automatic logic [7:0] f_sra(input logic [7:0] v, input logic [7:0] n);
        for (int i = 0; i < 8; i++) if (i < n) v = {v[7], v[7:1]};
        return v;
    endfunction

    function automatic string tag_of(input logic [7:0] ins, input logic taken, input logic [7:0] pc);
        if (taken) return "R10";
        if (ins == 8'hB4) return "R11";
        case (ins[7:4])
            4'd0, 4'd5:             return (pc == 8'hFF) ? "R12" : "R2";
            4'd1, 4'd2, 4'd3, 4'd4: return "R3";
            4'd6, 4'd7, 4'd8:       return "R4";
            4'd9:                   return "R5";
            4'd10, 4'd11:           return "R6";
            4'd12, 4'd13:           return "R7";
            4'd14:                  return "R8";
            default:                return "R9";
        endcase
    endfunction

    task automatic model_reset();
        m_pc = 8'h00; m_ret = 8'h00; m_flag = 1'b0; m_mask = 1'b0;
        for (int i = 0; i < 4; i++) m_r[i] = 8'h00;
        last_tag = "R1";
    endtask

    task automatic model_step(input logic irq_in);
        logic [7:0] ins, a, b, nxt;
        logic [1:0] d, s;
        ins = imem[m_pc];
        if (irq_in && !m_mask) begin
            m_ret = m_pc; m_pc = 8'h01; m_mask = 1'b1;
            return;
        end
        d = ins[3:2]; s = ins[1:0];
        a = m_r[d]; b = m_r[s];
        nxt = m_pc + 8'd1;
        case (ins[7:4])
            4'd0:  m_r[d] = b;
            4'd1:  m_r[d] = a + b;
            4'd2:  m_r[d] = a - b;
            4'd3:  m_r[d] = a & b;
            4'd4:  m_r[d] = a | b;
            4'd5:  m_r[d] = ~b;
            4'd6:  m_r[d] = f_sll(a, b);
            4'd7:  m_r[d] = f_srl(a, b);
            4'd8:  m_r[d] = f_sra(a, b);
            4'd9:  m_flag = (a == b);
            4'd10: if (d == 2'b00 && m_flag) nxt = b;
            4'd11: begin
                if (ins == 8'hB4) begin nxt = m_ret; m_mask = 1'b0; end
                else if (d == 2'b00) nxt = b;
            end
            4'd12: m_r[3][7:4] = ins[3:0];
            4'd13: m_r[3][3:0] = ins[3:0];
            4'd14: m_r[d] = mdmem[b];
            default: mdmem[b] = a;
        endcase
        m_pc = nxt;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // One compare-and-step per cycle; irq_pct sets the request rate.
    task automatic run_cycles(input int n, input int irq_pct);
        for (int c = 0; c < n; c++) begin
            logic [7:0] ins;
            logic       taken, exp_we;
            if (c > 0) @(negedge clk);
            irq = (($urandom % 100) < irq_pct);
            #1;
            ins    = imem[m_pc];
            taken  = irq && !m_mask;
            exp_we = !taken && ins[7:4] == 4'hF;
            chk(last_tag, imem_addr, m_pc);                     // fetch address after previous step
            chk(taken ? "R10" : "R9", {7'd0, dmem_we}, {7'd0, exp_we});
            if (exp_we) begin
                chk("R9", dmem_addr, m_r[ins[1:0]]);
                chk("R9", dmem_wdata, m_r[ins[3:2]]);
            end
            if (!taken && ins[7:4] == 4'hE) chk("R8", dmem_addr, m_r[ins[1:0]]);
            last_tag = tag_of(ins, taken, m_pc);
            model_step(irq);
        end
    endtask

    task automatic load_mems_random(input int iret_pct);
        for (int i = 0; i < 256; i++) begin
            imem[i] = (($urandom % 100) < iret_pct) ? 8'hB4 : 8'($urandom);
            dmem[i] = 8'($urandom);
            mdmem[i] = dmem[i];
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) begin
            imem[i] = 8'h00; dmem[i] = 8'h00; mdmem[i] = 8'h00;
        end

        // R1: reset state observed at the ports, including during reset.
        @(negedge clk);
        chk("R1", imem_addr, 8'h00);
        do_reset();
        #1;
        chk("R1", imem_addr, 8'h00);
        chk("R1", {7'd0, dmem_we}, 8'h00);

        // Directed: immediates and shifts at and beyond the width (R4, R7).
        imem[0]  = 8'hDF; imem[1]  = 8'hCF;   // r3 = FF
        imem[2]  = 8'h07;                     // mov r1,r3
        imem[3]  = 8'hD9; imem[4]  = 8'hC0;   // r3 = 09 (R7)
        imem[5]  = 8'h67;                     // sll r1,r3 -> 00 (R4)
        imem[6]  = 8'hF7;                     // st r1,[r3]
        imem[7]  = 8'hC8; imem[8]  = 8'hD0;   // r3 = 80
        imem[9]  = 8'h07;                     // mov r1,r3
        imem[10] = 8'hDA; imem[11] = 8'hC0;   // r3 = 0A
        imem[12] = 8'h87;                     // sra r1,r3 -> FF (R4)
        imem[13] = 8'hF7;                     // st r1,[r3]
        imem[14] = 8'hD3;                     // r3 = 03
        imem[15] = 8'h87;                     // sra r1,r3 (R4)
        imem[16] = 8'hF7;
        imem[17] = 8'h77;                     // srl r1,r3 (R4)
        imem[18] = 8'hF7;
        imem[19] = 8'h9F;                     // cmp r3,r3 -> flag 1 (R5)
        imem[20] = 8'hD8; imem[21] = 8'hC1;   // r3 = 18
        imem[22] = 8'hA3;                     // je r3 -> 0x18 (R6)
        imem[24] = 8'h5E;                     // not r3,r2 (R2)
        imem[25] = 8'hFF;                     // st r3,[r3]
        run_cycles(300, 0);                   // zeros pad to FF then wrap (R12)

        // Random programs at several interrupt rates (R2-R12).
        do_reset();
        load_mems_random(2);
        run_cycles(4000, 0);
        do_reset();
        load_mems_random(6);
        run_cycles(4000, 3);
        do_reset();
        load_mems_random(10);
        run_cycles(4000, 25);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule